// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a small set of dedicated interrupt lines coming from a general-purpose I/O port and turns qualifying pin activity into interrupt requests for a processor core. Each line has a two-bit sense mode that picks low level, any change, falling edge or rising edge, an enable bit, and a pending flag. Software reaches all of them over a byte-wide register bus. The port hands over each pin's current level together with a one-cycle change strobe. A strobe marks the cycle in which the level changed, and the level input already carries the new value in that cycle.

Each line is a three-state machine. LN_CLEAR means nothing is pending. LN_EDGE is a pending flag raised by an edge or change event, and software or an acknowledge may clear it. LN_LEVEL is a sticky flag raised by a low pin in low-level mode. LN_CLEAR goes to LN_EDGE on a qualifying strobe, or to LN_LEVEL when the pin is seen low, either on a strobe or on the re-check that follows any register write. LN_EDGE goes back to LN_CLEAR on a write-one clear, an acknowledge or a release. It goes to LN_LEVEL on a low-level set. LN_LEVEL goes to LN_CLEAR only when the pin rises while the line is enabled and in low-level mode. It turns into LN_EDGE if software moves the line out of low-level mode.

A shared arbiter has three states. ARB_IDLE goes to ARB_REQ when the global interrupt enable is high and some enabled flag is pending. On that transition the arbiter latches the lowest pending index. ARB_REQ presents the request and the vector. It goes to ARB_ENTER on an acknowledge. It falls back to ARB_IDLE if the global enable drops or the latched line stops pending. ARB_ENTER holds the request low for the entry cost of two cycles and then returns to ARB_IDLE.

Top module: `extint_sense_ctrl`

## Requirements
- R1: After reset, all four registers read 0 and irq_req is 0.
- R2: The sense field of line i sits at bits 2*(i mod 4)+1 : 2*(i mod 4). Lines 0 to 3 use address 0 and lines 4 to 7 use address 1. The encoding is 00 low level, 01 any change, 10 falling edge and 11 rising edge. Address 2 is the enable mask (bit i is line i). Address 3 is the flag register (bit i is line i).
- R3: A strobe on a line whose enable bit is 0 leaves that line's flag at 0.
- R4: In change, falling or rising mode, a strobe whose new level qualifies sets the flag. The flag is visible at address 3 after the clock edge that samples the strobe. A strobe that does not qualify leaves the flag unchanged.
- R5: Writing 1 to a flag bit raised by an edge or change event clears it. Writing 0 leaves it set.
- R6: In low-level mode, a falling strobe sets the flag. Neither a write of 1 to the flag nor an acknowledge clears it. A rising strobe clears it.
- R7: Any register write starts a re-check one cycle later. In that re-check, each enabled line that is in low-level mode and whose pin is low sets its flag.
- R8: irq_req is 1 only while global_ie is 1 and the line it serves is pending, meaning its flag and enable bits are both 1.
- R9: irq_vector equals 2 + 2*index of the served line. Among pending lines, the lowest index is served.
- R10: An acknowledge while irq_req is 1 clears an edge or change flag of the served line. irq_req then stays 0 for the next 2 cycles.
- R11: A read returns the current register contents: sense fields, enable mask and flags. Bits for absent lines read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 sense low lines, 1 sense high lines, 2 mask, 3 flags) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pin_level | input | NUM_LINES | Current pin levels |
| pin_toggle | input | NUM_LINES | One-cycle change strobes, new level on pin_level |
| global_ie | input | 1 | Global interrupt enable of the core |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | 8 | Word address of the served vector |

## Verification
If a line machine is in the wrong state, the next read of address 3 shows a wrong flag bit, and one cycle later the request presented by the arbiter starts or stops at the wrong time. If the arbiter latches the wrong winner, a wrong vector appears in the first cycle irq_req is high. If its entry count is wrong, irq_req comes back too early or too late after an acknowledge. A missed re-check or a lost sticky state shows as a low-level flag that is absent, or that clears on software write or acknowledge, in the cycle right after the register write or acknowledge that exposes it.

// File: rtl/extint_pkg.sv
package extint_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        LN_CLEAR = 2'd0,
        LN_EDGE  = 2'd1,
        LN_LEVEL = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_REQ   = 2'd1,
        ARB_ENTER = 2'd2
    } arb_state_e;

    localparam int ADDR_SENSE_LO = 0;
    localparam int ADDR_SENSE_HI = 1;
    localparam int ADDR_MASK     = 2;
    localparam int ADDR_FLAG     = 3;

endpackage

// File: rtl/extint_regfile.sv
module extint_regfile
    import extint_pkg::*;
#(
    parameter int NUM_LINES = 2,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [DATA_W-1:0]      wdata_i,
    input  logic [NUM_LINES-1:0]   flags_i,
    output logic [2*NUM_LINES-1:0] sense_o,
    output logic [NUM_LINES-1:0]   mask_o,
    output logic [NUM_LINES-1:0]   flag_clr_o,
    output logic                   recheck_o,
    output logic [DATA_W-1:0]      rdata_o
);

    localparam int FIELDS_PER_REG = DATA_W / 2;

    logic [1:0] sense_q [NUM_LINES];
    logic       unused_wdata;

    assign unused_wdata = ^wdata_i;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_field
        localparam int REG_SEL = i / FIELDS_PER_REG;
        localparam int BIT_OFF = 2 * (i % FIELDS_PER_REG);
        logic hit;
        assign hit = wr_en_i &&
            (addr_i == ADDR_W'((REG_SEL == 0) ? ADDR_SENSE_LO : ADDR_SENSE_HI));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   sense_q[i] <= 2'b00;
            else if (hit) sense_q[i] <= wdata_i[BIT_OFF +: 2];
        end
        assign sense_o[2*i +: 2] = sense_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o    <= '0;
            recheck_o <= 1'b0;
        end else begin
            recheck_o <= wr_en_i;
            if (wr_en_i && addr_i == ADDR_W'(ADDR_MASK))
                mask_o <= wdata_i[NUM_LINES-1:0];
        end
    end

    assign flag_clr_o = (wr_en_i && addr_i == ADDR_W'(ADDR_FLAG))
                        ? wdata_i[NUM_LINES-1:0] : '0;

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(ADDR_SENSE_LO): begin
                for (int i = 0; i < NUM_LINES; i++)
                    if (i / FIELDS_PER_REG == 0)
                        rdata_o[2*(i % FIELDS_PER_REG) +: 2] = sense_q[i];
            end
            ADDR_W'(ADDR_SENSE_HI): begin
                for (int i = 0; i < NUM_LINES; i++)
                    if (i / FIELDS_PER_REG == 1)
                        rdata_o[2*(i % FIELDS_PER_REG) +: 2] = sense_q[i];
            end
            ADDR_W'(ADDR_MASK): rdata_o[NUM_LINES-1:0] = mask_o;
            ADDR_W'(ADDR_FLAG): rdata_o[NUM_LINES-1:0] = flags_i;
            default:            rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/extint_line.sv
module extint_line
    import extint_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mask_i,
    input  logic [1:0] sense_i,
    input  logic       level_i,
    input  logic       toggle_i,
    input  logic       recheck_i,
    input  logic       sw_clr_i,
    input  logic       ack_i,
    output logic       flag_o
);

    line_state_e state_q, state_d;
    sense_e      mode;
    logic        is_low, edge_hit, level_set, level_release;

    assign mode   = sense_e'(sense_i);
    assign is_low = (mode == SENSE_LOW);

    always_comb begin
        edge_hit = 1'b0;
        if (toggle_i && mask_i) begin
            unique case (mode)
                SENSE_ANY:  edge_hit = 1'b1;
                SENSE_FALL: edge_hit = !level_i;
                SENSE_RISE: edge_hit = level_i;
                SENSE_LOW:  edge_hit = 1'b0;
                default:    edge_hit = 1'b0;
            endcase
        end
    end

    assign level_set     = mask_i && is_low && !level_i && (toggle_i || recheck_i);
    assign level_release = mask_i && is_low && toggle_i && level_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_CLEAR: begin
                if (level_set)     state_d = LN_LEVEL;
                else if (edge_hit) state_d = LN_EDGE;
            end
            LN_EDGE: begin
                if (level_set)     state_d = LN_LEVEL;
                else if (edge_hit) state_d = LN_EDGE;
                else if (level_release || sw_clr_i || ack_i)
                                   state_d = LN_CLEAR;
            end
            LN_LEVEL: begin
                if (level_release) state_d = LN_CLEAR;
                else if (!is_low)  state_d = LN_EDGE;
            end
            default: state_d = LN_CLEAR;
        endcase
    end

    always_comb flag_o = (state_q != LN_CLEAR);

    assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_CLEAR && !mask_i) |=> !flag_o);

    assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_LEVEL && !toggle_i) |=> flag_o);

    assert_edge_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_EDGE && (sw_clr_i || ack_i) && !toggle_i && !recheck_i)
        |=> !flag_o);

endmodule

// File: rtl/extint_arbiter.sv
module extint_arbiter
    import extint_pkg::*;
#(
    parameter int NUM_LINES    = 2,
    parameter int ENTRY_CYCLES = 2,
    parameter int VEC_W        = 8,
    parameter int VEC_BASE     = 2,
    parameter int VEC_STEP     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pend_i,
    input  logic                 global_ie_i,
    input  logic                 ack_i,
    output logic                 irq_req_o,
    output logic [VEC_W-1:0]     irq_vector_o,
    output logic [NUM_LINES-1:0] ack_line_o
);

    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam int CNT_W = (ENTRY_CYCLES > 1) ? $clog2(ENTRY_CYCLES) : 1;

    arb_state_e       state_q, state_d;
    logic [IDX_W-1:0] win_q, win_d, low_idx;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             any_pend, take;

    always_comb begin
        low_idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--)
            if (pend_i[i]) low_idx = IDX_W'(i);
    end
    assign any_pend = |pend_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            win_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            win_q   <= win_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        win_d   = win_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (global_ie_i && any_pend) begin
                    state_d = ARB_REQ;
                    win_d   = low_idx;
                end
            end
            ARB_REQ: begin
                if (take) begin
                    state_d = ARB_ENTER;
                    cnt_d   = '0;
                end else if (!global_ie_i || !pend_i[win_q]) begin
                    state_d = ARB_IDLE;
                end
            end
            ARB_ENTER: begin
                if (cnt_q == CNT_W'(ENTRY_CYCLES - 1)) state_d = ARB_IDLE;
                else                                   cnt_d   = cnt_q + 1'b1;
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    always_comb begin
        irq_req_o    = (state_q == ARB_REQ) && global_ie_i && pend_i[win_q];
        take         = irq_req_o && ack_i;
        ack_line_o   = take ? (NUM_LINES'(1) << win_q) : '0;
        irq_vector_o = VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(win_q);
    end

    assert_ack_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_line_o));

    assert_gap_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && ack_i) |=> !irq_req_o);

    assert_req_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_IDLE && !any_pend) |=> !irq_req_o);

endmodule

// File: rtl/extint_sense_ctrl.sv
module extint_sense_ctrl
    import extint_pkg::*;
#(
    parameter int NUM_LINES    = 2,
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 2,
    parameter int ENTRY_CYCLES = 2,
    parameter int VEC_W        = 8,
    parameter int VEC_BASE     = 2,
    parameter int VEC_STEP     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_LINES-1:0] pin_level,
    input  logic [NUM_LINES-1:0] pin_toggle,
    input  logic                 global_ie,
    input  logic                 irq_ack,
    output logic                 irq_req,
    output logic [VEC_W-1:0]     irq_vector
);

    logic [2*NUM_LINES-1:0] sense;
    logic [NUM_LINES-1:0]   mask, flags, flag_clr, ack_line, pend;
    logic                   recheck;

    extint_regfile #(
        .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (reg_wr_en),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .flags_i   (flags),
        .sense_o   (sense),
        .mask_o    (mask),
        .flag_clr_o(flag_clr),
        .recheck_o (recheck),
        .rdata_o   (reg_rdata)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        extint_line line_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .mask_i   (mask[i]),
            .sense_i  (sense[2*i +: 2]),
            .level_i  (pin_level[i]),
            .toggle_i (pin_toggle[i]),
            .recheck_i(recheck),
            .sw_clr_i (flag_clr[i]),
            .ack_i    (ack_line[i]),
            .flag_o   (flags[i])
        );
    end

    assign pend = flags & mask;

    extint_arbiter #(
        .NUM_LINES(NUM_LINES), .ENTRY_CYCLES(ENTRY_CYCLES), .VEC_W(VEC_W),
        .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
    ) arb_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_i      (pend),
        .global_ie_i (global_ie),
        .ack_i       (irq_ack),
        .irq_req_o   (irq_req),
        .irq_vector_o(irq_vector),
        .ack_line_o  (ack_line)
    );

endmodule

// File: tb/extint_sense_ctrl_tb.sv
module extint_sense_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 2;
    localparam int ENTRY      = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [7:0]   wdata = 8'd0;
    logic [7:0]   rdata;
    logic [N-1:0] lvl = '0;
    logic [N-1:0] tog = '0;
    logic         ie = 1'b0;
    logic         ack = 1'b0;
    logic         irq_req;
    logic [7:0]   irq_vector;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // bench model of the requirements
    int           m_st [N];
    logic [1:0]   m_sense [N];
    logic [N-1:0] m_mask;
    bit           m_rechk;
    int           a_st, a_win, a_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    extint_sense_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .pin_level(lvl),
        .pin_toggle(tog), .global_ie(ie), .irq_ack(ack),
        .irq_req(irq_req), .irq_vector(irq_vector)
    );

    function automatic bit m_pend(int i);
        return (m_st[i] != 0) && m_mask[i];
    endfunction

    function automatic bit m_req();
        return (a_st == 1) && ie && m_pend(a_win);
    endfunction

    function automatic logic [7:0] m_rdata(logic [1:0] a);
        logic [7:0] r = '0;
        for (int i = 0; i < N; i++) begin
            if (a == 2'd0 && i < 4) r[2*i +: 2] = m_sense[i];
            if (a == 2'd1 && i >= 4) r[2*(i-4) +: 2] = m_sense[i];
            if (a == 2'd2) r[i] = m_mask[i];
            if (a == 2'd3) r[i] = (m_st[i] != 0);
        end
        return r;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_st[i] = 0;
            m_sense[i] = 2'b00;
        end
        m_mask = '0; m_rechk = 0; a_st = 0; a_win = 0; a_cnt = 0;
    endtask

    task automatic model_step();
        int  nst [N];
        bit  take, any;
        int  low;
        take = m_req() && ack;
        for (int i = 0; i < N; i++) begin
            bit is_low, qual, lset, lrel, clr;
            is_low = (m_sense[i] == 2'b00);
            qual = tog[i] && m_mask[i] && !is_low &&
                   (m_sense[i] == 2'b01 || (m_sense[i] == 2'b10 && !lvl[i]) ||
                    (m_sense[i] == 2'b11 && lvl[i]));
            lset = m_mask[i] && is_low && !lvl[i] && (tog[i] || m_rechk);
            lrel = m_mask[i] && is_low && tog[i] && lvl[i];
            clr  = (wr && addr == 2'd3 && wdata[i]) || (take && a_win == i);
            case (m_st[i])
                0: nst[i] = lset ? 2 : (qual ? 1 : 0);
                1: nst[i] = lset ? 2 : (qual ? 1 : ((lrel || clr) ? 0 : 1));
                default: nst[i] = lrel ? 0 : (!is_low ? 1 : 2);
            endcase
        end
        any = 0; low = 0;
        for (int i = N - 1; i >= 0; i--) if (m_pend(i)) begin any = 1; low = i; end
        case (a_st)
            0: if (ie && any) begin a_st = 1; a_win = low; end
            1: if (take) begin a_st = 2; a_cnt = 0; end
               else if (!ie || !m_pend(a_win)) a_st = 0;
            default: if (a_cnt == ENTRY - 1) a_st = 0; else a_cnt++;
        endcase
        for (int i = 0; i < N; i++) m_st[i] = nst[i];
        if (wr && addr == 2'd0) for (int i = 0; i < N && i < 4; i++) m_sense[i] = wdata[2*i +: 2];
        if (wr && addr == 2'd1) for (int i = 4; i < N; i++) m_sense[i] = wdata[2*(i-4) +: 2];
        if (wr && addr == 2'd2) m_mask = wdata[N-1:0];
        m_rechk = wr;
    endtask

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_model();
        check("R8 request vs model", {31'd0, irq_req}, {31'd0, m_req()});
        if (m_req()) check("R9 vector vs model", {24'd0, irq_vector}, 2 + 2 * a_win);
        check("R11 readback vs model", {24'd0, rdata}, {24'd0, m_rdata(addr)});
    endtask

    task automatic cyc(bit w, logic [1:0] a, logic [7:0] d, logic [N-1:0] t, bit k);
        wr = w; addr = a; wdata = d; tog = t; lvl = lvl ^ t; ack = k;
        @(posedge clk);
        model_step();
        @(negedge clk);
        wr = 1'b0; tog = '0; ack = 1'b0;
        #1;
        compare_model();
    endtask

    task automatic idle();
        cyc(1'b0, addr, 8'd0, '0, 1'b0);
    endtask

    task automatic peek(logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int unused_seed;
        unused_seed = $urandom(32'h1c3b);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            peek(2'(a), v);
            check("R1 reset register", {24'd0, v}, 0);
        end
        check("R1 reset irq_req", {31'd0, irq_req}, 0);

        // R2 rising mode on both lines, field positions
        cyc(1, 2'd0, 8'h0F, '0, 0);
        peek(2'd0, v); check("R2 sense low readback", {24'd0, v}, 8'h0F);
        peek(2'd1, v); check("R2 sense high readback", {24'd0, v}, 0);

        // R3 disabled line ignores rise
        cyc(0, 2'd3, 8'h00, 2'b01, 0);
        peek(2'd3, v); check("R3 masked line flag", {24'd0, v}, 0);

        // R4 rising mode: falling strobe ignored, rising sets
        cyc(1, 2'd2, 8'h03, '0, 0);
        idle();
        cyc(0, 2'd3, 8'h00, 2'b01, 0);
        peek(2'd3, v); check("R4 falling in rise mode", {24'd0, v}, 0);
        cyc(0, 2'd3, 8'h00, 2'b01, 0);
        peek(2'd3, v); check("R4 rising sets flag", {24'd0, v}, 8'h01);

        // R8 no request without global enable
        repeat (3) idle();
        check("R8 no request with ie low", {31'd0, irq_req}, 0);

        // R5 write-zero no effect, write-one clears
        cyc(1, 2'd3, 8'h00, '0, 0);
        peek(2'd3, v); check("R5 write zero keeps flag", {24'd0, v}, 8'h01);
        cyc(1, 2'd3, 8'h01, '0, 0);
        peek(2'd3, v); check("R5 write one clears flag", {24'd0, v}, 0);

        // R9 priority and vectors
        cyc(0, 2'd3, 8'h00, 2'b10, 0);
        cyc(0, 2'd3, 8'h00, 2'b01, 0);
        cyc(0, 2'd3, 8'h00, 2'b01, 0);
        peek(2'd3, v); check("R4 both flags pending", {24'd0, v}, 8'h03);
        ie = 1'b1;
        idle();
        check("R8 request with ie high", {31'd0, irq_req}, 1);
        check("R9 lowest line vector", {24'd0, irq_vector}, 2);

        // R10 ack clears edge flag, two-cycle gap
        cyc(0, 2'd3, 8'h00, '0, 1);
        peek(2'd3, v); check("R10 ack clears served flag", {24'd0, v}, 8'h02);
        check("R10 gap cycle 1", {31'd0, irq_req}, 0);
        idle();
        check("R10 gap cycle 2", {31'd0, irq_req}, 0);
        idle();
        idle();
        check("R9 next request", {31'd0, irq_req}, 1);
        check("R9 line 1 vector", {24'd0, irq_vector}, 4);
        cyc(0, 2'd3, 8'h00, '0, 1);
        peek(2'd3, v); check("R10 ack clears line 1", {24'd0, v}, 0);

        // R6 low-level sticky flag
        cyc(1, 2'd0, 8'h00, '0, 0);
        cyc(0, 2'd3, 8'h00, 2'b01, 0);
        peek(2'd3, v); check("R6 low level sets flag", {24'd0, v}, 8'h01);
        cyc(1, 2'd3, 8'h01, '0, 0);
        peek(2'd3, v); check("R6 write one ignored", {24'd0, v}, 8'h01);
        check("R8 sticky request", {31'd0, irq_req}, 1);
        cyc(0, 2'd3, 8'h00, '0, 1);
        peek(2'd3, v); check("R6 ack ignored", {24'd0, v}, 8'h01);
        cyc(0, 2'd3, 8'h00, 2'b01, 0);
        peek(2'd3, v); check("R6 rise releases flag", {24'd0, v}, 0);

        // R7 re-check after register write
        ie = 1'b0;
        cyc(1, 2'd2, 8'h00, '0, 0);
        cyc(0, 2'd3, 8'h00, 2'b10, 0);
        peek(2'd3, v); check("R3 masked low pin ignored", {24'd0, v}, 0);
        cyc(1, 2'd2, 8'h02, '0, 0);
        peek(2'd3, v); check("R7 before re-check", {24'd0, v}, 0);
        idle();
        peek(2'd3, v); check("R7 re-check sets sticky", {24'd0, v}, 8'h02);
        cyc(0, 2'd3, 8'h00, 2'b10, 0);
        peek(2'd3, v); check("R6 release line 1", {24'd0, v}, 0);

        // R4 change and falling modes
        cyc(1, 2'd0, 8'h05, '0, 0);
        cyc(1, 2'd2, 8'h03, '0, 0);
        cyc(0, 2'd3, 8'h00, 2'b01, 0);
        peek(2'd3, v); check("R4 change mode on fall", {24'd0, v}, 8'h01);
        cyc(1, 2'd3, 8'h01, '0, 0);
        cyc(0, 2'd3, 8'h00, 2'b01, 0);
        peek(2'd3, v); check("R4 change mode on rise", {24'd0, v}, 8'h01);
        cyc(1, 2'd3, 8'h01, '0, 0);
        cyc(1, 2'd0, 8'h0A, '0, 0);
        cyc(0, 2'd3, 8'h00, 2'b01, 0);
        peek(2'd3, v); check("R4 falling mode on fall", {24'd0, v}, 8'h01);
        cyc(1, 2'd3, 8'h03, '0, 0);

        // random phase checked against the model
        for (int n = 0; n < 4000; n++) begin
            bit          w;
            logic [1:0]  a;
            logic [N-1:0] t;
            ie = ($urandom % 8) != 0;
            w  = ($urandom % 8) == 0;
            a  = 2'($urandom);
            t  = (($urandom % 4) == 0) ? N'($urandom) : '0;
            cyc(w, a, 8'($urandom), t, ($urandom % 3) == 0);
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule